// File: doc/BRIEF.md
# Hierarchical Inter-Ring Bridge

This block sits where one local unidirectional ring meets the global unidirectional ring. Both rings move one 58-bit flit per hop per cycle, and both share one clock. Every flit carries a one-hot ring mask in its top bits. Each set bit in the mask names a destination ring. A flit can name several rings, so one global flit can be copied down into more than one ring.

On the local side, a flit that names rings other than this one is lifted into an upward queue. That queue feeds free slots on the global ring. On the global side, a flit that names this ring is copied into a downward queue. That queue feeds free slots on the local ring. This ring's bit is then cleared from the global copy, and the copy travels on only if other bits remain. Flits that need no action pass through with one cycle of latency.

When the downward queue passes a threshold, the bridge raises a backpressure output. The system ORs every bridge's backpressure output into one halt input. While the halt is high, no bridge places new flits on the global ring. Flits already on the ring keep moving. No flit is ever dropped: if a queue is full, the flit stays on its own ring and comes round again.

Top module: `ring_bridge`

## Requirements
- R1: After a synchronous active-low reset, both ring outputs are invalid and the backpressure output is low.
- R2: A valid global flit whose mask bit 1 (this ring, mask in flit bits [57:54]) is set is copied into the downward queue with mask 4'b0010, provided the queue is not full. The global output on the next cycle carries the flit with bit 1 cleared if other bits remain. Otherwise that slot is empty.
- R3: A valid global flit without this ring's bit appears unchanged on the global output one cycle later.
- R4: A valid local flit whose mask has bits other than bit 1 is pushed into the upward queue with bit 1 cleared, provided that queue is not full. The local output then carries the flit with mask 4'b0010 if bit 1 was set. Otherwise that slot is empty.
- R5: A valid local flit whose mask is exactly 4'b0010 appears unchanged on the local output one cycle later.
- R6: The head of the upward queue goes onto the global output only in a slot left empty by R2/R3, and only while both the halt input and this bridge's backpressure output are low.
- R7: The head of the downward queue goes onto the local output only in a slot left empty by R4/R5.
- R8: The backpressure output is high exactly when the downward queue holds at least AF_LEVEL flits (default 3 of 4).
- R9: A flit that cannot be queued because its queue is full continues unchanged on its own ring. No flit is lost or duplicated.
- R10: Each queue keeps its flits in arrival order, so flits from one source reach a ring in the order they were sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared ring clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc_in_vld | input | 1 | Local ring slot arriving is occupied |
| loc_in_flit | input | 58 | Local ring flit in; mask in [57:54] |
| loc_out_vld | output | 1 | Local ring slot leaving is occupied |
| loc_out_flit | output | 58 | Local ring flit out |
| gbl_in_vld | input | 1 | Global ring slot arriving is occupied |
| gbl_in_flit | input | 58 | Global ring flit in |
| gbl_out_vld | output | 1 | Global ring slot leaving is occupied |
| gbl_out_flit | output | 58 | Global ring flit out |
| gbl_halt_in | input | 1 | OR of all bridges' backpressure; stops global injection |
| gbl_bp_out | output | 1 | This bridge's downward queue is near full |

## Verification
The hardest states to reach are both queues full at once and the backpressure edge that comes with them. In normal traffic, free slots drain the queues before they fill.

To reach these states, the bench holds the local ring fully occupied with pass-through flits while a burst of flits for this ring arrives on the global ring. The downward queue then cannot drain, rises past the threshold and overflows into R9 pass-through. A mirror burst does the same for the upward queue, with the global ring kept busy and the halt input held high.

A queue-based model then follows long random stretches with mixed multicast masks and a toggling halt input. This checks ordering and shows that no flit is lost or duplicated.

// File: rtl/rb_pkg.sv
// Package: default geometry shared by the bridge and its parts.
// Assumes the ring mask occupies the most significant bits of a flit.
package rb_pkg;
    localparam int DEF_FLIT_W  = 58;
    localparam int DEF_RINGS   = 4;
    localparam int DEF_DEPTH   = 4;
    localparam int DEF_AF      = 3;
endpackage

// File: rtl/rb_fifo.sv
// Module: rb_fifo
// Synchronous first-in first-out queue with a fill level output.
// Assumes the caller never pushes when full nor pops when empty;
// push and pop in one cycle are allowed.
module rb_fifo #(
    parameter int W     = rb_pkg::DEF_FLIT_W,
    parameter int DEPTH = rb_pkg::DEF_DEPTH
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic [W-1:0]                din,
    input  logic                        pop,
    output logic [W-1:0]                dout,
    output logic                        full,
    output logic                        empty,
    output logic [$clog2(DEPTH+1)-1:0]  level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
    assign level = cnt;
    assign dout  = mem[rd_ptr];

    // Storage write on push.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Pointer and count bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R9: the bridge must steer flits elsewhere rather than overfill.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R10: reading only happens when data is present.
    p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/rb_mask_split.sv
// Module: rb_mask_split
// Splits a ring mask into "names this ring" and "names other rings".
// Assumes OWN_ID is a valid index below N.
module rb_mask_split #(
    parameter int N      = rb_pkg::DEF_RINGS,
    parameter int OWN_ID = 1
) (
    input  logic [N-1:0] mask,
    output logic         hit_own,
    output logic [N-1:0] others
);
    localparam logic [N-1:0] OWN_BIT = N'(1) << OWN_ID;

    // Pure decode of the mask against this ring's one-hot code.
    always_comb begin
        hit_own = |(mask & OWN_BIT);
        others  = mask & ~OWN_BIT;
    end
endmodule

// File: rtl/ring_bridge.sv
// Module: ring_bridge
// Joins one local ring to the global ring. Lifts outbound flits through
// an upward queue, lowers flits for this ring through a downward queue,
// and forwards everything else one hop per cycle. Both rings share clk.
// Assumes gbl_halt_in is the OR of every bridge's gbl_bp_out.
module ring_bridge #(
    parameter int FLIT_W   = rb_pkg::DEF_FLIT_W,
    parameter int RINGS    = rb_pkg::DEF_RINGS,
    parameter int OWN_ID   = 1,
    parameter int UP_DEPTH = rb_pkg::DEF_DEPTH,
    parameter int DN_DEPTH = rb_pkg::DEF_DEPTH,
    parameter int AF_LEVEL = rb_pkg::DEF_AF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_in_vld,
    input  logic [FLIT_W-1:0] loc_in_flit,
    output logic              loc_out_vld,
    output logic [FLIT_W-1:0] loc_out_flit,
    input  logic              gbl_in_vld,
    input  logic [FLIT_W-1:0] gbl_in_flit,
    output logic              gbl_out_vld,
    output logic [FLIT_W-1:0] gbl_out_flit,
    input  logic              gbl_halt_in,
    output logic              gbl_bp_out
);
    localparam int MASK_LO = FLIT_W - RINGS;
    localparam int DCW     = $clog2(DN_DEPTH+1);
    localparam int UCW     = $clog2(UP_DEPTH+1);
    localparam logic [RINGS-1:0] OWN_BIT = RINGS'(1) << OWN_ID;

    logic               g_own, l_own;
    logic [RINGS-1:0]   g_oth, l_oth;
    logic               up_push, up_pop, up_full, up_empty;
    logic               dn_push, dn_pop, dn_full, dn_empty;
    logic [FLIT_W-1:0]  up_din, up_head, dn_din, dn_head;
    logic [DCW-1:0]     dn_level;
    logic [UCW-1:0]     up_level;
    logic               g_keep, l_keep, halt;
    logic [FLIT_W-1:0]  g_keep_flit, l_keep_flit;

    rb_mask_split #(.N(RINGS), .OWN_ID(OWN_ID)) u_gsplit (
        .mask(gbl_in_flit[FLIT_W-1:MASK_LO]), .hit_own(g_own), .others(g_oth));
    rb_mask_split #(.N(RINGS), .OWN_ID(OWN_ID)) u_lsplit (
        .mask(loc_in_flit[FLIT_W-1:MASK_LO]), .hit_own(l_own), .others(l_oth));

    rb_fifo #(.W(FLIT_W), .DEPTH(UP_DEPTH)) u_up (
        .clk(clk), .rst_n(rst_n), .push(up_push), .din(up_din), .pop(up_pop),
        .dout(up_head), .full(up_full), .empty(up_empty), .level(up_level));
    rb_fifo #(.W(FLIT_W), .DEPTH(DN_DEPTH)) u_dn (
        .clk(clk), .rst_n(rst_n), .push(dn_push), .din(dn_din), .pop(dn_pop),
        .dout(dn_head), .full(dn_full), .empty(dn_empty), .level(dn_level));

    assign gbl_bp_out = (dn_level >= DCW'(AF_LEVEL));
    assign halt       = gbl_halt_in | gbl_bp_out;

    // Global side: lower flits for this ring, keep the rest, fill holes.
    always_comb begin
        dn_push     = gbl_in_vld & g_own & ~dn_full;
        dn_din      = {OWN_BIT, gbl_in_flit[MASK_LO-1:0]};
        g_keep      = dn_push ? (|g_oth) : gbl_in_vld;
        g_keep_flit = dn_push ? {g_oth, gbl_in_flit[MASK_LO-1:0]} : gbl_in_flit;
        up_pop      = ~g_keep & ~up_empty & ~halt;
    end

    // Local side: lift flits bound elsewhere, keep the rest, fill holes.
    always_comb begin
        up_push     = loc_in_vld & (|l_oth) & ~up_full;
        up_din      = {l_oth, loc_in_flit[MASK_LO-1:0]};
        l_keep      = up_push ? l_own : loc_in_vld;
        l_keep_flit = up_push ? {OWN_BIT, loc_in_flit[MASK_LO-1:0]} : loc_in_flit;
        dn_pop      = ~l_keep & ~dn_empty;
    end

    // One-hop output registers for both rings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gbl_out_vld  <= 1'b0;
            gbl_out_flit <= '0;
            loc_out_vld  <= 1'b0;
            loc_out_flit <= '0;
        end else begin
            gbl_out_vld  <= g_keep | up_pop;
            gbl_out_flit <= g_keep ? g_keep_flit : up_head;
            loc_out_vld  <= l_keep | dn_pop;
            loc_out_flit <= l_keep ? l_keep_flit : dn_head;
        end
    end

    p_pass_global_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gbl_in_vld && !g_own) |=> (gbl_out_vld && gbl_out_flit == $past(gbl_in_flit)));
    p_pass_local_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_in_vld && loc_in_flit[FLIT_W-1:MASK_LO] == OWN_BIT)
        |=> (loc_out_vld && loc_out_flit == $past(loc_in_flit)));
    p_halt_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!gbl_in_vld && (gbl_halt_in || gbl_bp_out)) |=> !gbl_out_vld);
    p_bp_rises_on_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!gbl_bp_out && !dn_push) |=> !gbl_bp_out);
    p_full_keeps_flit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gbl_in_vld && g_own && dn_full)
        |=> (gbl_out_vld && gbl_out_flit == $past(gbl_in_flit)));
endmodule

// File: tb/tb_ring_bridge.sv
module tb_ring_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int FW = 58;
    localparam int NR = 4;
    localparam int UPD = 4;
    localparam int DND = 4;
    localparam int AF = 3;
    localparam logic [NR-1:0] OWN = 4'b0010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic loc_in_vld = 1'b0, gbl_in_vld = 1'b0, gbl_halt_in = 1'b0;
    logic [FW-1:0] loc_in_flit = '0, gbl_in_flit = '0;
    logic loc_out_vld, gbl_out_vld, gbl_bp_out;
    logic [FW-1:0] loc_out_flit, gbl_out_flit;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    string req_tag = "R1";
    int seq = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_bridge #(.FLIT_W(FW), .RINGS(NR), .OWN_ID(1), .UP_DEPTH(UPD),
                  .DN_DEPTH(DND), .AF_LEVEL(AF)) dut (
        .clk(clk), .rst_n(rst_n),
        .loc_in_vld(loc_in_vld), .loc_in_flit(loc_in_flit),
        .loc_out_vld(loc_out_vld), .loc_out_flit(loc_out_flit),
        .gbl_in_vld(gbl_in_vld), .gbl_in_flit(gbl_in_flit),
        .gbl_out_vld(gbl_out_vld), .gbl_out_flit(gbl_out_flit),
        .gbl_halt_in(gbl_halt_in), .gbl_bp_out(gbl_bp_out));

    // Behavioural reference: two queues and expected output slots.
    logic [FW-1:0] upq[$];
    logic [FW-1:0] dnq[$];
    logic e_gv = 1'b0, e_lv = 1'b0, e_bp = 1'b0;
    logic [FW-1:0] e_gf = '0, e_lf = '0;

    always @(posedge clk) begin
        int us, ds;
        bit hlt, gfree, lfree;
        logic [NR-1:0] m;
        if (!rst_n) begin
            upq.delete(); dnq.delete();
            e_gv = 0; e_lv = 0; e_gf = '0; e_lf = '0; e_bp = 0;
        end else begin
            us = upq.size(); ds = dnq.size();
            hlt = gbl_halt_in || (ds >= AF);
            // global ring
            gfree = 1; e_gv = 0;
            if (gbl_in_vld) begin
                m = gbl_in_flit[FW-1 -: NR];
                if ((m & OWN) != 0 && ds < DND) begin
                    dnq.push_back({OWN, gbl_in_flit[FW-NR-1:0]});
                    if ((m & ~OWN) != 0) begin
                        gfree = 0; e_gv = 1; e_gf = {m & ~OWN, gbl_in_flit[FW-NR-1:0]};
                    end
                end else begin
                    gfree = 0; e_gv = 1; e_gf = gbl_in_flit;
                end
            end
            if (gfree && us > 0 && !hlt) begin
                e_gv = 1; e_gf = upq.pop_front();
            end
            // local ring
            lfree = 1; e_lv = 0;
            if (loc_in_vld) begin
                m = loc_in_flit[FW-1 -: NR];
                if ((m & ~OWN) != 0 && us < UPD) begin
                    upq.push_back({m & ~OWN, loc_in_flit[FW-NR-1:0]});
                    if ((m & OWN) != 0) begin
                        lfree = 0; e_lv = 1; e_lf = {OWN, loc_in_flit[FW-NR-1:0]};
                    end
                end else begin
                    lfree = 0; e_lv = 1; e_lf = loc_in_flit;
                end
            end
            if (lfree && ds > 0) begin
                e_lv = 1; e_lf = dnq.pop_front();
            end
            e_bp = (dnq.size() >= AF);
        end
    end

    task automatic check(input string what, input logic [FW:0] act, input logic [FW:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req_tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check("gbl_out", {gbl_out_vld, gbl_out_vld ? gbl_out_flit : '0},
                         {e_gv, e_gv ? e_gf : '0});
        check("loc_out", {loc_out_vld, loc_out_vld ? loc_out_flit : '0},
                         {e_lv, e_lv ? e_lf : '0});
        check("bp_out", {{FW{1'b0}}, gbl_bp_out}, {{FW{1'b0}}, e_bp});
    endtask

    function automatic logic [FW-1:0] mk(input logic [NR-1:0] m, input int id);
        return {m, 22'd0, 32'(id)};
    endfunction

    task automatic cyc(input logic lv, input logic [NR-1:0] lm,
                       input logic gv, input logic [NR-1:0] gm, input logic h);
        @(negedge clk);
        compare_all();
        loc_in_vld = lv; loc_in_flit = mk(lm, seq); seq++;
        gbl_in_vld = gv; gbl_in_flit = mk(gm, seq); seq++;
        gbl_halt_in = h;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 4'b0, 0, 4'b0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        req_tag = "R1";
        check("reset", {gbl_bp_out, gbl_out_vld, loc_out_vld}, '0);
        rst_n = 1'b1;
        idle(2);
        req_tag = "R3"; cyc(0, 0, 1, 4'b0100, 0); cyc(0, 0, 1, 4'b1001, 0); idle(3);
        req_tag = "R2"; cyc(0, 0, 1, 4'b0010, 0); cyc(0, 0, 1, 4'b0110, 0); idle(2);
        req_tag = "R7"; cyc(1, 4'b0010, 1, 4'b0010, 0); cyc(1, 4'b0010, 0, 0, 0); idle(4);
        req_tag = "R5"; cyc(1, 4'b0010, 0, 0, 0); cyc(1, 4'b0010, 0, 0, 0); idle(2);
        req_tag = "R4"; cyc(1, 4'b1000, 0, 0, 0); cyc(1, 4'b1010, 0, 0, 0); idle(4);
        req_tag = "R6";
        for (int i = 0; i < 3; i++) cyc(1, 4'b0001, 0, 0, 1);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1);
        idle(6);
        // Fill the downward queue: local ring kept busy.
        req_tag = "R8";
        for (int i = 0; i < 4; i++) cyc(1, 4'b0010, 1, 4'b0010, 0);
        req_tag = "R9";
        for (int i = 0; i < 4; i++) cyc(1, 4'b0010, 1, 4'b0110, 0);
        req_tag = "R8"; idle(8);
        // Fill the upward queue: global ring kept busy and halted.
        req_tag = "R9";
        for (int i = 0; i < 8; i++) cyc(1, 4'b1100, 1, 4'b0100, 1);
        req_tag = "R6"; idle(8);
        // Mixed random traffic for ordering and loss checks.
        req_tag = "R10";
        for (int i = 0; i < 3000; i++)
            cyc(1'($urandom % 2), 4'($urandom), 1'($urandom % 3 != 0), 4'($urandom),
                1'($urandom % 5 == 0));
        idle(12);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog %s: actual hung expected finished", req_tag);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule